// File: doc/BRIEF.md
# Dual-Rail Four-Phase Channel Endpoints

This block is a pair of clocked endpoints for a one-bit channel that uses dual-rail encoding and a four-phase, return-to-zero handshake. The sender accepts bits on a valid/ready input port. It encodes each bit onto a pair of one-hot rails: the true rail for a 1 and the false rail for a 0. It then follows an active-high enable wire that the far end drives back. The receiver watches a pair of incoming rails. It acknowledges by pulling its enable low and presents each decoded bit on a valid/ready output port.

The two halves are separate at the ports. A bench or a larger system can loop them back directly, or place a chain of asynchronous pipeline stages between the sender's rails and the receiver's rails. Every asynchronous input (the enable at the sender, the two rails at the receiver) passes through a two-flop synchronizer before any state machine uses it.

The sender stops accepting bits once it has taken a programmable number of them since reset. The receiver counts the bits it has delivered and raises a sticky flag if it ever sees both rails high at once. The active-low reset returns both halves to the idle channel state.

Top module: `drc_link`

## Requirements
- R1: While reset is held and right after it is released, tx_true and tx_false are 0, rx_enable is 1, out_valid is 0, rx_error is 0, rx_count is 0, tx_done is 0 and in_ready is 1 (for a non-zero tx_quota).
- R2: A bit of value 1 is sent by raising tx_true and a bit of value 0 by raising tx_false. tx_true and tx_false are never high together.
- R3: The sender raises a rail only while tx_enable is high and both rails are low. It holds the rail until tx_enable goes low, and it raises no new rail until tx_enable has returned high.
- R4: The receiver pulls rx_enable low only after it sees exactly one incoming rail high. It raises rx_enable only after both rails are low again and out_valid has been cleared by a transfer on the output port.
- R5: Decoded bits leave on out_data in the order they were accepted on in_data. While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data holds its value.
- R6: rx_count equals the number of bits the receiver has decoded since reset.
- R7: The sender accepts at most tx_quota bits since reset. Once that many have been taken, tx_done is 1 and in_ready is 0, and further in_valid has no effect on the channel.
- R8: If both incoming rails are seen high together, rx_error goes to 1 and stays 1 until reset. Such a state is not decoded: neither out_valid nor rx_count changes.
- R9: Reset asserted in the middle of a transfer drops both sender rails and raises rx_enable, and a transfer after release completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both endpoints |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Bit offered to the sender |
| in_data | input | 1 | Value of the offered bit |
| in_ready | output | 1 | Sender can take a bit this cycle |
| tx_quota | input | CNT_W | Number of bits the sender may take since reset |
| tx_done | output | 1 | Quota reached |
| tx_true | output | 1 | Sender true rail |
| tx_false | output | 1 | Sender false rail |
| tx_enable | input | 1 | Enable returned to the sender (high = ready for data) |
| rx_true | input | 1 | Receiver true rail |
| rx_false | input | 1 | Receiver false rail |
| rx_enable | output | 1 | Enable driven by the receiver |
| out_valid | output | 1 | Decoded bit available |
| out_ready | input | 1 | Consumer takes the bit |
| out_data | output | 1 | Decoded bit value |
| rx_count | output | CNT_W | Bits decoded since reset |
| rx_error | output | 1 | Sticky flag: both rails seen high |

## Verification
The channel is looped back and driven with all-zero and all-one streams, so that each rail is exercised on its own. Alternating patterns and a pseudo-random stream then check that the rail selection follows every bit and that order is kept. Each stream is drained under a different consumer pacing: always ready, every other cycle, one in four, and one in thirty-two. This separates a receiver that re-arms its enable on rail return alone from one that also waits for the output buffer. Directed cases hold the consumer off indefinitely, exhaust the quota, inject both rails high, and reset mid-transfer.

// File: rtl/drc_pkg.sv
package drc_pkg;

  typedef enum logic [1:0] {TX_IDLE, TX_DATA, TX_WACK, TX_RTZ} tx_state_t;
  typedef enum logic [1:0] {RX_IDLE, RX_ACK, RX_RTZ} rx_state_t;
  typedef enum logic [1:0] {RAIL_NULL, RAIL_ZERO, RAIL_ONE, RAIL_BAD} rail_code_t;

  // bit -> {true, false}
  function automatic logic [1:0] rail_encode(input logic b);
    return b ? 2'b10 : 2'b01;
  endfunction

  function automatic rail_code_t rail_decode(input logic t, input logic f);
    case ({t, f})
      2'b00:   return RAIL_NULL;
      2'b01:   return RAIL_ZERO;
      2'b10:   return RAIL_ONE;
      default: return RAIL_BAD;
    endcase
  endfunction

endpackage

// File: rtl/drc_sync.sv
module drc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= (i == 0) ? d : stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/drc_sender.sv
module drc_sender
  import drc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_data,
  output logic             in_ready,
  input  logic [CNT_W-1:0] quota,
  output logic             done,
  output logic             rail_t,
  output logic             rail_f,
  input  logic             en_in
);
  tx_state_t        state;
  logic [CNT_W-1:0] sent_cnt;
  logic             en_s;
  logic             rail_up;
  logic             accept;
  logic             below_quota;

  drc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_en_sync (
    .clk(clk), .rst_n(rst_n), .d(en_in), .q(en_s)
  );

  assign below_quota = sent_cnt < quota;
  assign done        = !below_quota;
  assign in_ready    = (state == TX_IDLE) && en_s && below_quota;
  assign accept      = in_valid && in_ready;
  assign rail_up     = rail_t | rail_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= TX_IDLE;
      rail_t   <= 1'b0;
      rail_f   <= 1'b0;
      sent_cnt <= '0;
    end else begin
      case (state)
        TX_IDLE: if (accept) begin
          {rail_t, rail_f} <= rail_encode(in_data);
          sent_cnt         <= sent_cnt + CNT_W'(1);
          state            <= TX_DATA;
        end
        TX_DATA: state <= TX_WACK;
        TX_WACK: if (!en_s) begin
          rail_t <= 1'b0;
          rail_f <= 1'b0;
          state  <= TX_RTZ;
        end
        default: if (en_s) state <= TX_IDLE;
      endcase
    end
  end

  // R3
  rail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_up) |-> $past(en_s));
  // R3
  rail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_up) |-> !$past(en_s));
  // R7
  quota_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_up) |-> $past(sent_cnt) < $past(quota));
endmodule

// File: rtl/drc_receiver.sv
module drc_receiver
  import drc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rail_t,
  input  logic             rail_f,
  output logic             en_out,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_data,
  output logic [CNT_W-1:0] count,
  output logic             err
);
  rx_state_t  state;
  logic [1:0] rails_s;
  rail_code_t cls;
  logic       got_bit;
  logic       rails_null;

  drc_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_rail_sync (
    .clk(clk), .rst_n(rst_n), .d({rail_t, rail_f}), .q(rails_s)
  );

  assign cls        = rail_decode(rails_s[1], rails_s[0]);
  assign got_bit    = (cls == RAIL_ONE) || (cls == RAIL_ZERO);
  assign rails_null = (cls == RAIL_NULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      en_out    <= 1'b1;
      out_valid <= 1'b0;
      out_data  <= 1'b0;
      count     <= '0;
      err       <= 1'b0;
    end else begin
      if (cls == RAIL_BAD) err <= 1'b1;
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (state)
        RX_IDLE: if (got_bit) begin
          out_data  <= (cls == RAIL_ONE);
          out_valid <= 1'b1;
          count     <= count + CNT_W'(1);
          en_out    <= 1'b0;
          state     <= RX_ACK;
        end
        RX_ACK: if (rails_null) state <= RX_RTZ;
        default: if (rails_null && !out_valid) begin
          en_out <= 1'b1;
          state  <= RX_IDLE;
        end
      endcase
    end
  end

  // R4
  en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_out) |-> $past(rails_s[1] ^ rails_s[0]));
  // R4
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_out) |-> $past(rails_s == 2'b00 && !out_valid));
  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/drc_link.sv
module drc_link #(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_data,
  output logic             in_ready,
  input  logic [CNT_W-1:0] tx_quota,
  output logic             tx_done,
  output logic             tx_true,
  output logic             tx_false,
  input  logic             tx_enable,
  input  logic             rx_true,
  input  logic             rx_false,
  output logic             rx_enable,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_data,
  output logic [CNT_W-1:0] rx_count,
  output logic             rx_error
);
  drc_sender #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .quota(tx_quota), .done(tx_done),
    .rail_t(tx_true), .rail_f(tx_false), .en_in(tx_enable)
  );

  drc_receiver #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .rail_t(rx_true), .rail_f(rx_false),
    .en_out(rx_enable), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .count(rx_count), .err(rx_error)
  );

  // R2
  rails_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_true, tx_false}));
endmodule

// File: tb/drc_link_tb.sv
`timescale 1ns/1ps
module drc_link_tb_top;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_data = 1'b0, out_ready = 1'b0;
  logic [CW-1:0] tx_quota = 16'hFFFF;
  logic inj_t = 1'b0, inj_f = 1'b0;
  logic in_ready, tx_done, tx_true, tx_false, tx_enable, rx_true, rx_false;
  logic rx_enable, out_valid, out_data, rx_error;
  logic [CW-1:0] rx_count;

  int errors = 0, checks = 0, total = 0;
  logic last_sent = 1'b0;
  logic mon_en = 1'b0;

  always #2 clk = ~clk;

  assign rx_true   = tx_true | inj_t;
  assign rx_false  = tx_false | inj_f;
  assign tx_enable = rx_enable;

  drc_link #(.CNT_W(CW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .tx_quota(tx_quota), .tx_done(tx_done),
    .tx_true(tx_true), .tx_false(tx_false), .tx_enable(tx_enable),
    .rx_true(rx_true), .rx_false(rx_false), .rx_enable(rx_enable),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .rx_count(rx_count), .rx_error(rx_error)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // stimulus vectors: [22:21] ready pacing, [20:16] length-1, [15:0] bits (LSB first)
  localparam logic [22:0] VEC [5] = '{
    {2'd0, 5'd15, 16'h0000},
    {2'd1, 5'd15, 16'hFFFF},
    {2'd2, 5'd15, 16'hA5C3},
    {2'd0, 5'd0,  16'h0001},
    {2'd3, 5'd15, 16'h0F0F}
  };

  int cyc = 0;
  always @(posedge clk) cyc++;

  function automatic logic pace(input int mode, input int c);
    case (mode)
      0: return 1'b1;
      1: return c[0];
      2: return c[1:0] == 2'd0;
      default: return c[4:0] == 5'd31;
    endcase
  endfunction

  // port monitors, sampled 1 ns after the edge
  logic pv = 1'b0, pd = 1'b0, pt = 1'b0, pf = 1'b0;
  always @(posedge clk) begin
    #1;
    if (rst_n && mon_en) begin
      if (tx_true && tx_false) chk(0, "R2", "both sender rails high", 1, 0);
      if ((tx_true && !pt) || (tx_false && !pf)) begin
        chk(tx_enable == 1'b1, "R3", "enable at rail rise", tx_enable, 1);
        chk(tx_true == last_sent, "R2", "rail chosen for bit", tx_true, last_sent);
      end
      if ((!tx_true && pt) || (!tx_false && pf))
        chk(tx_enable == 1'b0, "R3", "enable at rail fall", tx_enable, 0);
      if (pv && !out_ready) begin
        chk(out_valid == 1'b1, "R5", "valid held under stall", out_valid, 1);
        chk(out_data == pd, "R5", "data held under stall", out_data, pd);
      end
    end
    pv = out_valid; pd = out_data; pt = tx_true; pf = tx_false;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    total = 0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    last_sent = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_vec(input logic [31:0] pat, input int n, input int mode);
    logic [31:0] got;
    got = '0;
    fork
      begin
        for (int i = 0; i < n; i++) send_bit(pat[i]);
      end
      begin
        int k;
        k = 0;
        while (k < n) begin
          @(negedge clk);
          out_ready = pace(mode, cyc);
          if (out_valid && out_ready) begin
            got[k] = out_data;
            k++;
          end
        end
        @(negedge clk);
        out_ready = 1'b0;
      end
    join
    for (int i = 0; i < n; i++)
      chk(got[i] == pat[i], "R5", $sformatf("bit %0d in order", i), got[i], pat[i]);
    total += n;
    chk(rx_count == CW'(total), "R6", "received count", rx_count, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [31:0] rnd;
    // R1 reset state, during and after reset
    repeat (3) @(negedge clk);
    chk(tx_true == 0 && tx_false == 0, "R1", "rails in reset", {tx_true, tx_false}, 0);
    chk(rx_enable == 1, "R1", "enable in reset", rx_enable, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && rx_error == 0, "R1", "valid/error after reset", {out_valid, rx_error}, 0);
    chk(rx_count == 0, "R1", "count after reset", rx_count, 0);
    chk(in_ready == 1 && tx_done == 0, "R1", "ready/done after reset", {in_ready, tx_done}, 2);
    mon_en = 1'b1;

    // R2 R5 R6 table of patterns and pacing
    for (int v = 0; v < 5; v++)
      run_vec({16'h0, VEC[v][15:0]}, int'(VEC[v][20:16]) + 1, int'(VEC[v][22:21]));

    // pseudo-random stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 32; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rnd[i] = lfsr[0];
    end
    run_vec(rnd, 32, 1);

    // R4 consumer held off: enable must stay low
    do_reset();
    out_ready = 1'b0;
    send_bit(1'b1);
    repeat (30) @(negedge clk);
    chk(out_valid == 1 && out_data == 1, "R4", "bit waiting", {out_valid, out_data}, 3);
    chk(rx_enable == 0, "R4", "enable low while buffer full", rx_enable, 0);
    chk(in_ready == 0, "R4", "sender blocked", in_ready, 0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    repeat (12) @(negedge clk);
    chk(rx_enable == 1, "R4", "enable re-raised after drain", rx_enable, 1);
    chk(in_ready == 1, "R4", "sender ready again", in_ready, 1);

    // R7 quota
    tx_quota = 16'd3;
    do_reset();
    @(negedge clk);
    chk(tx_done == 0, "R7", "done before quota", tx_done, 0);
    run_vec(32'b101, 3, 0);
    repeat (15) @(negedge clk);
    chk(tx_done == 1 && in_ready == 0, "R7", "done/ready at quota", {tx_done, in_ready}, 2);
    in_valid = 1'b1; in_data = 1'b1;
    repeat (40) @(negedge clk);
    in_valid = 1'b0;
    chk(tx_true == 0 && tx_false == 0, "R7", "no rail past quota", {tx_true, tx_false}, 0);
    chk(rx_count == 3, "R7", "count past quota", rx_count, 3);

    // R8 both rails injected
    tx_quota = 16'hFFFF;
    do_reset();
    out_ready = 1'b1;
    @(negedge clk);
    inj_t = 1'b1; inj_f = 1'b1;
    repeat (6) @(negedge clk);
    inj_t = 1'b0; inj_f = 1'b0;
    repeat (6) @(negedge clk);
    chk(rx_error == 1, "R8", "error flagged", rx_error, 1);
    chk(rx_count == 0 && out_valid == 0, "R8", "illegal not decoded", {rx_count, out_valid}, 0);
    chk(rx_enable == 1, "R8", "enable untouched", rx_enable, 1);
    run_vec(32'b0, 1, 0);
    chk(rx_error == 1, "R8", "error sticky", rx_error, 1);
    do_reset();
    @(negedge clk);
    chk(rx_error == 0, "R8", "error cleared by reset", rx_error, 0);

    // R9 reset mid-transfer
    out_ready = 1'b1;
    send_bit(1'b0);
    repeat (4) @(negedge clk);
    chk(rx_enable == 0 && tx_false == 1, "R9", "transfer in flight", {rx_enable, tx_false}, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(tx_true == 0 && tx_false == 0, "R9", "rails dropped", {tx_true, tx_false}, 0);
    chk(rx_enable == 1, "R9", "enable raised", rx_enable, 1);
    rst_n = 1'b1;
    total = 0;
    run_vec(32'b10, 2, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule